// File: doc/BRIEF.md
# Multi-Mode Colour Palette Register File

This block holds the colour palette of a display controller and exposes it to a host through four byte-wide ports: an index port and one port each for green, red and blue. The same four ports mean different things depending on which of three storage modes is active. In packed digital mode, each port is a packed 8-bit colour entry. In 16-colour analog mode and 256-colour extended mode, the index port holds a palette number and the colour ports address one channel of that palette entry in a shared linear byte store. Reads return whatever the matching write would have stored.

A display pipeline reads colours through a separate combinational lookup port. The block raises a sticky redraw request whenever a write changes something visible, and the display side clears it with a one-cycle acknowledge. After reset, a sequencer writes one byte per clock over the whole store. It loads the 16-entry analog defaults and a computed 256-entry default table. During this fill the block reports busy and ignores host writes.

Top module: `pal_regfile`

## Requirements
- R1: Reset fill. While reset is asserted, `busy` is 1 and `redrawReq` is 0. After reset is released, `busy` stays 1 for exactly 1072 clock edges (one per byte of the linear store) and then stays 0 for good. `redrawReq` rises on the same edge on which `busy` falls. A host write made while `busy` is 1 changes nothing.
- R2: Packed entries 0..3 reset to 0x04, 0x15, 0x26 and 0x37.
- R3: The 16 analog entries reset from these 12-bit words, listed from entry 0 to entry 15: 000, 007, 070, 077, 700, 707, 770, 777, 444, 00F, 0F0, 0FF, F00, F0F, FF0, FFF (hex). In each word, bits 11:8 are green, bits 7:4 are red and bits 3:0 are blue. Each channel is stored as a byte with the value zero-extended.
- R4: The 256 extended entries reset in groups of eight. Let the group base be b = 8·(n/8), and let j = n mod 8. Entry n with j = 0 holds (b == 0 ? 0 : b−4) in all three channels. For j ≠ 0, green is (b+7)·j[2], red is (b+7)·j[1] and blue is (b+7)·j[0].
- R5: `hostSel` encoding: 0 is the index port, 1 green, 2 red, 3 blue. When either analog mode input is 1, an index write stores the whole byte as the palette number and does not touch `redrawReq`. Otherwise an index write goes to packed entry 3.
- R6: In packed mode (both mode inputs 0), green writes go to packed entry 1, red writes to entry 2 and blue writes to entry 0.
- R7: A packed-entry write (through the index port or a colour port) always stores the new byte. It sets `redrawReq` only when (old XOR new) AND 0x77 is non-zero.
- R8: In 16-colour mode (`modeAna16`=1, `modeAna256`=0), a colour write stores the byte at linear address palnum·3+k, where k is 0 for green, 1 for red and 2 for blue, using the full 8-bit palnum. It also updates displayed entry palnum[3:0], channel k, and sets `redrawReq`.
- R9: When `modeAna256` is 1, whatever the value of `modeAna16`, a colour write stores the byte at linear address 48+palnum·4+k and always sets `redrawReq`. The 16-colour store address and the displayed 16 entries are left unchanged.
- R10: Reads mirror writes. The index port returns palnum in either analog mode and packed entry 3 otherwise. A colour port returns the 256-mode slot, else the 16-mode slot, else its packed entry, tested in that order.
- R11: `redrawReq` is sticky until a cycle with `redrawAck`=1 clears it. A set and an acknowledge in the same cycle leave it at 1.
- R12: Lookup port, combinational. In 256 mode it returns the three channels of extended entry `lookupIdx`. In 16 mode it returns displayed entry `lookupIdx[3:0]`. In packed mode `lookupG` is packed entry `lookupIdx[1:0]`, and `lookupR` and `lookupB` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| modeAna16 | input | 1 | 16-colour analog mode enable |
| modeAna256 | input | 1 | 256-colour extended mode enable (priority over 16) |
| hostWr | input | 1 | Host write strobe, one byte per cycle |
| hostSel | input | 2 | Port select: 0 index, 1 green, 2 red, 3 blue |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Combinational read data for `hostSel` |
| lookupIdx | input | 8 | Display lookup entry number |
| lookupG | output | 8 | Looked-up green |
| lookupR | output | 8 | Looked-up red |
| lookupB | output | 8 | Looked-up blue |
| redrawReq | output | 1 | Sticky redraw request |
| redrawAck | input | 1 | One-cycle clear of `redrawReq` |
| busy | output | 1 | Reset fill in progress |

## Verification
A wrong address computation shows up in the very next combinational read: the byte read back through the same port under the same palette number does not match the byte just written. A wrong computation can also leave its trace in an overlapping slot, where a 16-mode write with a large palette number lands inside the 256-entry region and becomes visible through the lookup port. A fill sequencer that is off by one byte or one group shows up as a wrong default at the lookup port as soon as `busy` falls, or as a wrong busy length. A mistake in the redraw mask or in the set-over-acknowledge priority shows on `redrawReq` one edge after the write.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int DATA_W  = 8;
  localparam int CH_N    = 3;
  localparam int ENT16   = 16;
  localparam int ENT256  = 256;
  localparam int SLOT    = 4;
  localparam int PK_N    = 4;
  localparam int BASE256 = ENT16 * CH_N;
  localparam int DEPTH   = BASE256 + ENT256 * SLOT;
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int DISP_W  = $clog2(BASE256);
  localparam int IDX16_W = $clog2(ENT16);
  localparam int PKSEL_W = $clog2(PK_N);
  localparam int GROUP   = 8;
  localparam logic [DATA_W-1:0] PK_MASK = 8'h77;

  typedef enum logic [1:0] {SEL_IDX = 2'd0, SEL_G = 2'd1, SEL_R = 2'd2, SEL_B = 2'd3} portSel_t;
  typedef enum logic [1:0] {RD_PAL, RD_PACK, RD_TBL} rdSrc_t;

  typedef struct packed {
    logic                tblWe;
    logic [ADDR_W-1:0]   tblAddr;
    logic                dispWe;
    logic [DISP_W-1:0]   dispAddr;
    logic [DATA_W-1:0]   wrData;
    logic                pkWe;
    logic [PKSEL_W-1:0]  pkSel;
    logic                idxWe;
    logic                setRedraw;
    rdSrc_t              rdSrc;
    logic [ADDR_W-1:0]   rdAddr;
    logic [PKSEL_W-1:0]  rdPkSel;
  } palStrobe_t;

  // packed entry reset value: entry number in high nibble, entry+4 in low nibble
  function automatic logic [DATA_W-1:0] pkReset(input int e);
    return DATA_W'((e << 4) | (e + 4));
  endfunction

  // packed entry addressed by a colour port
  function automatic logic [PKSEL_W-1:0] pkOfPort(input logic [1:0] sel);
    case (sel)
      SEL_G:   return PKSEL_W'(1);
      SEL_R:   return PKSEL_W'(2);
      SEL_B:   return PKSEL_W'(0);
      default: return PKSEL_W'(3);
    endcase
  endfunction

  // default content of one byte of the linear store
  function automatic logic [DATA_W-1:0] defaultByte(input logic [ADDR_W-1:0] a);
    int unsigned ad, e, k, n, b, j, bitv;
    ad = int'(a);
    if (ad < BASE256) begin
      e = ad / CH_N;
      k = ad % CH_N;
      bitv = (e >> (2 - k)) & 1;
      if (e < GROUP)       return DATA_W'(7 * bitv);
      else if (e == GROUP) return DATA_W'(4);
      else                 return DATA_W'(15 * bitv);
    end
    n = (ad - BASE256) / SLOT;
    k = (ad - BASE256) % SLOT;
    if (k >= CH_N) return '0;
    b = (n / GROUP) * GROUP;
    j = n % GROUP;
    if (j == 0) return (b == 0) ? '0 : DATA_W'(b - 4);
    bitv = (j >> (2 - k)) & 1;
    return (bitv != 0) ? DATA_W'(b + 7) : '0;
  endfunction
endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeAna16,
  input  logic               modeAna256,
  input  logic               hostWr,
  input  logic [1:0]         hostSel,
  input  logic [DATA_W-1:0]  hostWdata,
  input  logic [DATA_W-1:0]  palNum,
  input  logic [DATA_W-1:0]  pkQ [PK_N],
  output logic               busy,
  output palStrobe_t         st
);
  logic [ADDR_W-1:0]  fillAddr;
  logic               fillLast;
  logic               analog;
  logic [1:0]         chK;
  logic [ADDR_W-1:0]  addr256;
  logic [ADDR_W-1:0]  addr16;
  logic [DISP_W-1:0]  disp16;
  logic [PKSEL_W-1:0] colPk;
  logic               pkChange;
  logic [PKSEL_W-1:0] wrPk;

  assign fillLast = (fillAddr == ADDR_W'(DEPTH - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillAddr <= '0;
      busy     <= 1'b1;
    end else if (busy) begin
      fillAddr <= fillAddr + ADDR_W'(1);
      if (fillLast) busy <= 1'b0;
    end
  end

  assign analog  = modeAna16 | modeAna256;
  assign chK     = hostSel - 2'd1;
  assign addr256 = ADDR_W'(BASE256) + ADDR_W'(palNum) * ADDR_W'(SLOT) + ADDR_W'(chK);
  assign addr16  = ADDR_W'(palNum) * ADDR_W'(CH_N) + ADDR_W'(chK);
  assign disp16  = DISP_W'(palNum[IDX16_W-1:0]) * DISP_W'(CH_N) + DISP_W'(chK);
  assign colPk   = pkOfPort(hostSel);
  assign wrPk    = (hostSel == SEL_IDX) ? PKSEL_W'(3) : colPk;
  assign pkChange = |((pkQ[wrPk] ^ hostWdata) & PK_MASK);

  always_comb begin
    st = '0;
    // read routing, mirrors the write decode
    if (hostSel == SEL_IDX) begin
      st.rdSrc   = analog ? RD_PAL : RD_PACK;
      st.rdPkSel = PKSEL_W'(3);
    end else if (modeAna256) begin
      st.rdSrc  = RD_TBL;
      st.rdAddr = addr256;
    end else if (modeAna16) begin
      st.rdSrc  = RD_TBL;
      st.rdAddr = addr16;
    end else begin
      st.rdSrc   = RD_PACK;
      st.rdPkSel = colPk;
    end

    // write routing
    if (busy) begin
      st.tblWe     = 1'b1;
      st.tblAddr   = fillAddr;
      st.wrData    = defaultByte(fillAddr);
      st.dispWe    = (fillAddr < ADDR_W'(BASE256));
      st.dispAddr  = fillAddr[DISP_W-1:0];
      st.setRedraw = fillLast;
    end else if (hostWr) begin
      st.wrData = hostWdata;
      if (hostSel == SEL_IDX && analog) begin
        st.idxWe = 1'b1;
      end else if (hostSel != SEL_IDX && modeAna256) begin
        st.tblWe     = 1'b1;
        st.tblAddr   = addr256;
        st.setRedraw = 1'b1;
      end else if (hostSel != SEL_IDX && modeAna16) begin
        st.tblWe     = 1'b1;
        st.tblAddr   = addr16;
        st.dispWe    = 1'b1;
        st.dispAddr  = disp16;
        st.setRedraw = 1'b1;
      end else begin
        st.pkWe      = 1'b1;
        st.pkSel     = wrPk;
        st.setRedraw = pkChange;
      end
    end
  end
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  palStrobe_t         st,
  input  logic               modeAna16,
  input  logic               modeAna256,
  input  logic [DATA_W-1:0]  lookupIdx,
  input  logic               redrawAck,
  output logic [DATA_W-1:0]  palNum,
  output logic [DATA_W-1:0]  pkQ [PK_N],
  output logic [DATA_W-1:0]  hostRdata,
  output logic [DATA_W-1:0]  lkCh [CH_N],
  output logic               redrawReq
);
  logic [DATA_W-1:0] tbl  [DEPTH];
  logic [DATA_W-1:0] disp [BASE256];
  logic [ADDR_W-1:0] lkBase256;
  logic [DISP_W-1:0] lkBase16;

  always_ff @(posedge clk) begin
    if (st.tblWe) tbl[st.tblAddr] <= st.wrData;
  end

  always_ff @(posedge clk) begin
    if (st.dispWe) disp[st.dispAddr] <= st.wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < PK_N; e++) pkQ[e] <= pkReset(e);
    end else if (st.pkWe) begin
      pkQ[st.pkSel] <= st.wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         palNum <= '0;
    else if (st.idxWe) palNum <= st.wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) redrawReq <= 1'b0;
    else       redrawReq <= st.setRedraw | (redrawReq & ~redrawAck);
  end

  always_comb begin
    case (st.rdSrc)
      RD_PAL:  hostRdata = palNum;
      RD_PACK: hostRdata = pkQ[st.rdPkSel];
      RD_TBL:  hostRdata = tbl[st.rdAddr];
      default: hostRdata = '0;
    endcase
  end

  assign lkBase256 = ADDR_W'(BASE256) + ADDR_W'(lookupIdx) * ADDR_W'(SLOT);
  assign lkBase16  = DISP_W'(lookupIdx[IDX16_W-1:0]) * DISP_W'(CH_N);

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_lk
    if (ch == 0) begin : g_first
      assign lkCh[ch] = modeAna256 ? tbl[lkBase256 + ADDR_W'(ch)]
                      : modeAna16  ? disp[lkBase16 + DISP_W'(ch)]
                      : pkQ[lookupIdx[PKSEL_W-1:0]];
    end else begin : g_rest
      assign lkCh[ch] = modeAna256 ? tbl[lkBase256 + ADDR_W'(ch)]
                      : modeAna16  ? disp[lkBase16 + DISP_W'(ch)]
                      : '0;
    end
  end
endmodule

// File: rtl/pal_regfile.sv
module pal_regfile
  import pal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeAna16,
  input  logic              modeAna256,
  input  logic              hostWr,
  input  logic [1:0]        hostSel,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  input  logic [7:0]        lookupIdx,
  output logic [7:0]        lookupG,
  output logic [7:0]        lookupR,
  output logic [7:0]        lookupB,
  output logic              redrawReq,
  input  logic              redrawAck,
  output logic              busy
);
  palStrobe_t        st;
  logic [DATA_W-1:0] palNum;
  logic [DATA_W-1:0] pkQ  [PK_N];
  logic [DATA_W-1:0] lkCh [CH_N];

  pal_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeAna16  (modeAna16),
    .modeAna256 (modeAna256),
    .hostWr     (hostWr),
    .hostSel    (hostSel),
    .hostWdata  (hostWdata),
    .palNum     (palNum),
    .pkQ        (pkQ),
    .busy       (busy),
    .st         (st)
  );

  pal_store u_store (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .modeAna16  (modeAna16),
    .modeAna256 (modeAna256),
    .lookupIdx  (lookupIdx),
    .redrawAck  (redrawAck),
    .palNum     (palNum),
    .pkQ        (pkQ),
    .hostRdata  (hostRdata),
    .lkCh       (lkCh),
    .redrawReq  (redrawReq)
  );

  assign lookupG = lkCh[0];
  assign lookupR = lkCh[1];
  assign lookupB = lkCh[2];
endmodule

// File: rtl/pal_regfile_chk.sv
module pal_regfile_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostWr,
  input logic [1:0] hostSel,
  input logic       modeAna16,
  input logic       modeAna256,
  input logic       redrawReq,
  input logic       redrawAck,
  input logic       busy
);
  // R1
  fill_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !redrawReq);

  // R1
  busy_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> !busy);

  // R11
  redraw_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (redrawReq && !redrawAck) |=> redrawReq);

  // R11
  redraw_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(redrawReq) |-> ($past(hostWr) || $fell(busy)));

  // R9
  wide_write_redraw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !busy && modeAna256 && hostSel != 2'd0) |=> redrawReq);

  // R8
  narrow_write_redraw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !busy && modeAna16 && hostSel != 2'd0) |=> redrawReq);
endmodule

bind pal_regfile pal_regfile_chk u_chk (.*);

// File: tb/pal_regfile_tb.sv
module pal_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDEPTH     = 1072;
  localparam int NBASE      = 48;
  localparam int RAND_OPS   = 400;
  localparam int WATCHDOG   = 200000;
  localparam int SEED       = 20240611;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeAna16 = 1'b0, modeAna256 = 1'b0;
  logic       hostWr = 1'b0;
  logic [1:0] hostSel = 2'd0;
  logic [7:0] hostWdata = 8'd0;
  logic [7:0] hostRdata;
  logic [7:0] lookupIdx = 8'd0;
  logic [7:0] lookupG, lookupR, lookupB;
  logic       redrawReq;
  logic       redrawAck = 1'b0;
  logic       busy;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  logic [7:0] mTbl [NDEPTH];
  logic [7:0] mDisp [NBASE];
  logic [7:0] mPk [4];
  logic [7:0] mPal;
  bit         mRedraw;

  logic [11:0] anaWord [16] = '{12'h000, 12'h007, 12'h070, 12'h077, 12'h700, 12'h707,
                                12'h770, 12'h777, 12'h444, 12'h00f, 12'h0f0, 12'h0ff,
                                12'hf00, 12'hf0f, 12'hff0, 12'hfff};

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_regfile u_dut (.*);

  function automatic logic [7:0] expDefault(int a);
    int off, n, k, b, j;
    logic [11:0] w;
    if (a < NBASE) begin
      w = anaWord[a / 3];
      k = a % 3;
      return {4'b0, w[(2 - k) * 4 +: 4]};
    end
    off = a - NBASE; n = off / 4; k = off % 4;
    if (k == 3) return 8'd0;
    b = (n / 8) * 8; j = n % 8;
    if (j == 0) return (b == 0) ? 8'd0 : 8'(b - 4);
    return ((j >> (2 - k)) & 1) ? 8'(b + 7) : 8'd0;
  endfunction

  function automatic int pkOf(int s);
    return (s == 1) ? 1 : (s == 2) ? 2 : (s == 3) ? 0 : 3;
  endfunction

  function automatic logic [7:0] expRead(int s);
    if (s == 0) return (modeAna16 || modeAna256) ? mPal : mPk[3];
    if (modeAna256) return mTbl[NBASE + int'(mPal) * 4 + s - 1];
    if (modeAna16)  return mTbl[int'(mPal) * 3 + s - 1];
    return mPk[pkOf(s)];
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic checkPorts(string tag);
    for (int s = 0; s < 4; s++) begin
      hostSel = 2'(s);
      #1;
      check8(tag, hostRdata, expRead(s));
    end
  endtask

  task automatic checkLookup(string tag, int idx);
    int b;
    lookupIdx = 8'(idx);
    #1;
    for (int ch = 0; ch < 3; ch++) begin
      logic [7:0] act, exp;
      act = (ch == 0) ? lookupG : (ch == 1) ? lookupR : lookupB;
      if (modeAna256) begin
        b = NBASE + idx * 4; exp = mTbl[b + ch];
      end else if (modeAna16) begin
        b = (idx % 16) * 3; exp = mDisp[b + ch];
      end else begin
        exp = (ch == 0) ? mPk[idx % 4] : 8'd0;
      end
      check8(tag, act, exp);
    end
  endtask

  task automatic checkRedraw(string tag);
    check8(tag, {7'd0, redrawReq}, {7'd0, mRedraw});
  endtask

  task automatic hostWrite(int s, logic [7:0] d, bit ack);
    bit set;
    int a;
    @(negedge clk);
    hostWr = 1'b1; hostSel = 2'(s); hostWdata = d; redrawAck = ack;
    set = 1'b0;
    if (s == 0 && (modeAna16 || modeAna256)) begin
      mPal = d;
    end else if (s != 0 && modeAna256) begin
      mTbl[NBASE + int'(mPal) * 4 + s - 1] = d; set = 1'b1;
    end else if (s != 0 && modeAna16) begin
      a = int'(mPal) * 3 + s - 1;
      mTbl[a] = d;
      mDisp[(int'(mPal) % 16) * 3 + s - 1] = d;
      set = 1'b1;
    end else begin
      set = ((mPk[pkOf(s)] ^ d) & 8'h77) != 0;
      mPk[pkOf(s)] = d;
    end
    mRedraw = set || (mRedraw && !ack);
    @(negedge clk);
    hostWr = 1'b0; redrawAck = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk);
    redrawAck = 1'b1;
    mRedraw = 1'b0;
    @(negedge clk);
    redrawAck = 1'b0;
  endtask

  task automatic setMode(bit m16, bit m256);
    modeAna16 = m16; modeAna256 = m256;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL R1 watchdog expired actual running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    int unsigned seedInit;
    seedInit = $urandom(SEED);
    for (int a = 0; a < NDEPTH; a++) mTbl[a] = expDefault(a);
    for (int a = 0; a < NBASE; a++) mDisp[a] = expDefault(a);
    mPk[0] = 8'h04; mPk[1] = 8'h15; mPk[2] = 8'h26; mPk[3] = 8'h37;
    mPal = 8'd0; mRedraw = 1'b0;

    repeat (3) @(negedge clk);
    check8("R1 busy in reset", {7'd0, busy}, 8'd1);
    check8("R1 redraw in reset", {7'd0, redrawReq}, 8'd0);

    rstN = 1'b1;
    cnt = 0;
    @(negedge clk); cnt++;
    hostWr = 1'b1; hostSel = 2'd0; hostWdata = 8'hAA;   // ignored during fill
    @(negedge clk); cnt++;
    hostWr = 1'b0;
    while (busy === 1'b1 && cnt < 5000) begin
      @(negedge clk); cnt++;
    end
    check8("R1 fill length low", 8'(cnt), 8'(NDEPTH));
    check8("R1 fill length high", 8'(cnt >> 8), 8'(NDEPTH >> 8));
    mRedraw = 1'b1;
    checkRedraw("R1 redraw after fill");
    setMode(0, 0);
    checkPorts("R2 R1 packed defaults and ignored write");
    hostSel = 2'd0; #1; check8("R1 ignored write", hostRdata, 8'h37);

    pulseAck();
    checkRedraw("R11 ack clears");

    setMode(1, 0);
    for (int e = 0; e < 16; e++) checkLookup("R3 analog default", e);
    lookupIdx = 8'd9; #1; check8("R3 entry 9 blue", lookupB, 8'h0f);
    setMode(0, 1);
    for (int e = 0; e < 256; e++) checkLookup("R4 extended default", e);
    lookupIdx = 8'd16; #1; check8("R4 group 16 entry 0", lookupG, 8'd12);
    lookupIdx = 8'd21; #1; check8("R4 entry 21 green", lookupG, 8'd23);

    setMode(1, 0);
    hostWrite(0, 8'h9C, 0);
    hostSel = 2'd0; #1; check8("R5 index analog", hostRdata, 8'h9C);
    checkRedraw("R5 index analog no redraw");
    setMode(0, 0);
    hostSel = 2'd0; #1; check8("R5 index digital read", hostRdata, 8'h37);
    hostWrite(0, 8'h30, 0);
    hostSel = 2'd0; #1; check8("R5 index digital write", hostRdata, 8'h30);
    checkRedraw("R7 index packed change");

    pulseAck();
    hostWrite(1, 8'h15 ^ 8'h88, 0);
    checkRedraw("R7 masked bits no redraw");
    hostSel = 2'd1; #1; check8("R7 value stored", hostRdata, 8'h9D);
    hostWrite(1, 8'h9C, 0);
    checkRedraw("R7 visible change");

    hostWrite(2, 8'hA2, 0);
    hostWrite(3, 8'hB0, 0);
    checkPorts("R6 packed map");
    for (int e = 0; e < 4; e++) checkLookup("R12 packed lookup", e);
    lookupIdx = 8'd0; #1; check8("R6 blue in entry 0", lookupG, 8'hB0);

    pulseAck();
    setMode(1, 0);
    hostWrite(0, 8'h13, 0);
    hostWrite(1, 8'h0A, 0);
    checkRedraw("R8 analog write redraw");
    hostSel = 2'd1; #1; check8("R8 readback", hostRdata, 8'h0A);
    lookupIdx = 8'd3; #1; check8("R8 low nibble display", lookupG, 8'h0A);
    setMode(0, 1);
    lookupIdx = 8'd2; #1; check8("R8 overlap linear", lookupR, 8'h0A);

    pulseAck();
    setMode(1, 1);
    hostWrite(0, 8'h05, 0);
    hostWrite(3, 8'h5A, 0);
    checkRedraw("R9 extended redraw");
    hostSel = 2'd3; #1; check8("R9 priority read", hostRdata, 8'h5A);
    setMode(1, 0);
    hostSel = 2'd3; #1; check8("R9 narrow slot untouched", hostRdata, 8'h07);
    lookupIdx = 8'd5; #1; check8("R9 display untouched", lookupB, 8'h07);

    setMode(0, 1);
    hostWrite(2, 8'h11, 1);
    checkRedraw("R11 set wins over ack");

    for (int it = 0; it < RAND_OPS; it++) begin
      int r;
      if (it % 16 == 0) setMode(($urandom % 2) == 1, ($urandom % 3) == 0);
      r = $urandom % 100;
      if (r < 75)      hostWrite($urandom % 4, 8'($urandom), ($urandom % 10) == 0);
      else if (r < 90) pulseAck();
      else             @(negedge clk);
      checkRedraw("R11 random redraw");
      checkPorts("R10 random readback");
      checkLookup("R12 random lookup", $urandom % 256);
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule